// File: doc/BRIEF.md
# Internal Data-Space Access Unit

This block resolves every access to the internal data space of an 8-bit controller. The space holds 256 bytes of on-chip RAM and a bank of special function registers (SFRs). The SFRs share the address range 80H–FFH with the upper half of the RAM but are stored separately. Each request supplies an 8-bit address, a flag that marks the access as direct or indirect, read and write strobes, and a write byte. The unit steers the request to lower RAM, upper RAM or the SFR bank, and returns the byte read one clock later.

For any address from 80H upward, the addressing mode picks the target. A direct access goes to the SFR bank. An indirect access, which includes every stack push and pop, goes to upper RAM. This holds even where an SFR exists at the same address. The unit also raises an SFR select strobe and an SFR write strobe, and presents the reset value of the addressed SFR, so that peripheral logic placed next to it can follow register traffic.

An implemented SFR starts at its defined reset value. Bits that the register leaves undefined read back as zero and cannot be written. An address in the SFR range that has no register reads as 00H and drops writes.

Top module: `dspace_unit`

## Requirements
- R1: For addresses 00H–7FH, a write and a later read reach the same lower-RAM byte, whatever the direct/indirect flag is for either access.
- R2: A direct access (acc_indirect=0) to an implemented address 80H–FFH targets the SFR bank. `sfr_sel` is 1 during the access, and `sfr_we` is 1 when it is a write.
- R3: An indirect access (acc_indirect=1) to 80H–FFH targets upper RAM, which is separate from the SFR at the same address. `sfr_sel` and `sfr_we` are 0 during it.
- R4: After reset, a direct read returns the reset value. The stack pointer (81H) reads 07H. The port latches 80H, 90H, A0H and B0H read FFH. Every other implemented SFR reads 00H. The implemented set is 80H–83H, 87H–8DH, 90H, 98H, 99H, A0H, A8H, B0H, B8H, C8H–CDH, D0H, E0H and F0H.
- R5: Undefined bits read as 0 and ignore writes. These bits are bit 6 of A8H, bits 7:6 of B8H, bits 7:2 of C9H and bits 6:4 of 87H. Writing FFH to these registers reads back BFH, 3FH, 03H and 8FH respectively.
- R6: A direct access to an address in 80H–FFH that is not in the implemented set reads 00H, discards writes and keeps `sfr_sel` at 0.
- R7: `rd_data` is registered. A read presented at a rising edge appears on `rd_data` after that edge. `rd_data` holds its value when `rd_en` is 0, and it is 00H after reset.
- R8: A read and a write to the same location in the same cycle return the old contents. The new value is visible to the next read.
- R9: `sfr_rstval` shows the reset value of the addressed SFR while `sfr_sel` is 1, and 00H otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | 8 | Data-space address |
| acc_indirect | input | 1 | 1 = indirect access, 0 = direct access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| sfr_sel | output | 1 | Direct access to an implemented SFR |
| sfr_we | output | 1 | Write to an implemented SFR |
| sfr_rstval | output | 8 | Reset value of the selected SFR, else 00H |

## Verification
Each address is reached in both modes: a byte written one way is read the other way, in lower RAM and in the overlaid upper range. This separates correct steering from a mode flag that is ignored or inverted. Writing all-ones to the registers with undefined bits and to an empty SFR address separates correct masking from plain storage. Back-to-back and simultaneous read/write cycles, along with idle cycles, show whether the read register returns old data and holds its value.

// File: rtl/dspace_unit.sv
module dspace_unit #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_indirect,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sfr_sel,
  output logic          sfr_we,
  output logic [DW-1:0] sfr_rstval
);
  localparam int RAM_DEPTH = 1 << AW;
  localparam int SFR_DEPTH = RAM_DEPTH / 2;
  localparam int IW = 2 * DW + 1;

  function automatic logic [IW-1:0] sfr_info(input logic [AW-2:0] idx);
    logic [IW-1:0] r;
    case ({1'b1, idx})
      8'h80, 8'h90, 8'hA0, 8'hB0: r = {1'b1, 8'hFF, 8'hFF};
      8'h81:                      r = {1'b1, 8'h07, 8'hFF};
      8'h87:                      r = {1'b1, 8'h00, 8'h8F};
      8'hA8:                      r = {1'b1, 8'h00, 8'hBF};
      8'hB8:                      r = {1'b1, 8'h00, 8'h3F};
      8'hC9:                      r = {1'b1, 8'h00, 8'h03};
      8'h82, 8'h83, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D,
      8'h98, 8'h99, 8'hC8, 8'hCA, 8'hCB, 8'hCC, 8'hCD,
      8'hD0, 8'hE0, 8'hF0:        r = {1'b1, 8'h00, 8'hFF};
      default:                    r = '0;
    endcase
    return r;
  endfunction

  logic [DW-1:0] ram   [RAM_DEPTH];
  logic [DW-1:0] sfr_q [SFR_DEPTH];

  wire            to_sfr = acc_addr[AW-1] & ~acc_indirect;
  wire [AW-2:0]   sidx   = acc_addr[AW-2:0];
  wire [IW-1:0]   info   = sfr_info(sidx);
  wire            impl   = info[IW-1];
  wire [DW-1:0]   rstv   = info[2*DW-1:DW];
  wire [DW-1:0]   wmask  = info[DW-1:0];
  wire [DW-1:0]   rd_mux = to_sfr ? sfr_q[sidx] : ram[acc_addr];

  assign sfr_sel    = to_sfr & impl & (rd_en | wr_en);
  assign sfr_we     = sfr_sel & wr_en;
  assign sfr_rstval = sfr_sel ? rstv : '0;

  always_ff @(posedge clk)
    if (wr_en && !to_sfr) ram[acc_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SFR_DEPTH; i++) begin
        logic [IW-1:0] ri;
        ri = sfr_info((AW-1)'(i));
        sfr_q[i] <= ri[2*DW-1:DW];
      end
    end else if (sfr_we) begin
      sfr_q[sidx] <= wr_data & wmask;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R7
  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> (sfr_sel && wr_en)); // R2
  AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_indirect |-> (!sfr_sel && !sfr_we)); // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_indirect && acc_addr[AW-1] && !sfr_sel) |=> rd_data == '0); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_indirect && acc_addr == 8'hA8) |=> !rd_data[6]); // R5
  AST_RSTVAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_sel |-> sfr_rstval == '0); // R9
endmodule

// File: tb/tb_dspace_unit.sv
module tb_dspace_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_addr = '0;
  logic       acc_indirect = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sfr_sel;
  logic       sfr_we;
  logic [7:0] sfr_rstval;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  dspace_unit dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [7:0] a, input logic ind, input logic rd, input logic wr,
                     input logic [7:0] wd, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_addr = a; acc_indirect = ind; rd_en = rd; wr_en = wr; wr_data = wd;
    if (rd) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && rd_en) begin
      #2;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard: got %02h expected nothing", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk(rd_data, 8'h00, "R7 reset rd_data");

    // R4 reset values, R9 reset-value output
    acc(8'h81, 0, 1, 0, 0, 8'h07, "R4 SP");
    #1 chk(sfr_rstval, 8'h07, "R9 rstval SP");
    acc(8'h80, 0, 1, 0, 0, 8'hFF, "R4 port 80");
    acc(8'h90, 0, 1, 0, 0, 8'hFF, "R4 port 90");
    #1 chk(sfr_rstval, 8'hFF, "R9 rstval 90");
    acc(8'hA0, 0, 1, 0, 0, 8'hFF, "R4 port A0");
    acc(8'hB0, 0, 1, 0, 0, 8'hFF, "R4 port B0");
    acc(8'hE0, 0, 1, 0, 0, 8'h00, "R4 E0");
    acc(8'hA8, 0, 1, 0, 0, 8'h00, "R4 A8");
    acc(8'hC9, 0, 1, 0, 0, 8'h00, "R4 C9");

    // R1 lower RAM mode-independent
    acc(8'h10, 0, 0, 1, 8'h5A, 0, "");
    acc(8'h10, 1, 1, 0, 0, 8'h5A, "R1 direct wr, indirect rd");
    acc(8'h7F, 1, 0, 1, 8'hC3, 0, "");
    #1 chk({7'b0, sfr_sel}, 8'h00, "R1 sfr_sel low at 7F");
    acc(8'h7F, 0, 1, 0, 0, 8'hC3, "R1 indirect wr, direct rd");

    // R7 hold when idle
    acc(8'h20, 0, 0, 0, 0, 0, "");
    @(posedge clk); #2 chk(rd_data, 8'hC3, "R7 hold without rd_en");

    // R2 / R3 overlaid space
    acc(8'hE0, 0, 0, 1, 8'h11, 0, "");
    #1 chk({6'b0, sfr_sel, sfr_we}, 8'h03, "R2 sel/we on direct write");
    acc(8'hE0, 1, 0, 1, 8'h22, 0, "");
    #1 chk({6'b0, sfr_sel, sfr_we}, 8'h00, "R3 no sel on indirect write");
    acc(8'hE0, 0, 1, 0, 0, 8'h11, "R2 SFR E0 kept");
    acc(8'hE0, 1, 1, 0, 0, 8'h22, "R3 upper RAM E0");
    acc(8'h81, 1, 0, 1, 8'h44, 0, "");
    acc(8'h81, 0, 1, 0, 0, 8'h07, "R3 stack write spares SP");

    // R5 reserved bits
    acc(8'hA8, 0, 0, 1, 8'hFF, 0, "");
    acc(8'hA8, 0, 1, 0, 0, 8'hBF, "R5 A8 mask");
    acc(8'hB8, 0, 0, 1, 8'hFF, 0, "");
    acc(8'hB8, 0, 1, 0, 0, 8'h3F, "R5 B8 mask");
    acc(8'hC9, 0, 0, 1, 8'hFF, 0, "");
    acc(8'hC9, 0, 1, 0, 0, 8'h03, "R5 C9 mask");
    acc(8'h87, 0, 0, 1, 8'hFF, 0, "");
    acc(8'h87, 0, 1, 0, 0, 8'h8F, "R5 87 mask");

    // R6 unimplemented
    acc(8'h85, 0, 0, 1, 8'hAA, 0, "");
    #1 chk({7'b0, sfr_sel}, 8'h00, "R6 no sel at 85");
    #0 chk(sfr_rstval, 8'h00, "R9 rstval unimpl");
    acc(8'h85, 0, 1, 0, 0, 8'h00, "R6 unimpl read");
    acc(8'h85, 1, 0, 1, 8'hAA, 0, "");
    acc(8'h85, 1, 1, 0, 0, 8'hAA, "R6 upper RAM at 85 intact");

    // R8 read-during-write
    acc(8'h30, 0, 0, 1, 8'h01, 0, "");
    acc(8'h30, 0, 1, 1, 8'h02, 8'h01, "R8 RAM old value");
    acc(8'h30, 0, 1, 0, 0, 8'h02, "R8 RAM new value");
    acc(8'hF0, 0, 0, 1, 8'h66, 0, "");
    acc(8'hF0, 0, 1, 1, 8'h77, 8'h66, "R8 SFR old value");
    acc(8'hF0, 0, 1, 0, 0, 8'h77, "R8 SFR new value");

    acc(8'h00, 0, 0, 0, 0, 0, "");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule